// File: doc/BRIEF.md
# One-Time-Programmable Array Direct-Access Sequencer

This block turns a software-style command strobe into a single read or programming access on a one-time-programmable storage array. Software first loads a byte address and up to two 32-bit data words. It then writes a two-bit command, with one bit for read and one for program. The sequencer looks up which partition the address falls in. That partition's entry in a parameter table sets the access granule to 32 or 64 bits. The sequencer aligns the address to that granule and drives one request on a simple request/acknowledge memory port. It then captures the returned data and reports the outcome.

The outcome appears as a three-bit status field and a three-bit error code. It is also signalled by a one-cycle completion interrupt and a one-cycle error interrupt. Errors fall into four recovery classes:
- Some clear when the next command is accepted.
- A missing-initialisation error clears when initialisation completes.
- Read and program failures stay latched until reset.
- An escalation is terminal.

Initialisation is started by a pulse and lasts a fixed, parameterised number of cycles.

Top module: `otp_cmd_seq`

## Requirements
- R1: After reset, status reads 0 (idle), the error code reads 0 (none), no memory request is pending, and both interrupts are low.
- R2: A command given before initialisation has completed, or while it is running, starts no memory access and sets error code 1. An init pulse shows status 1 for INIT_CYCLES cycles. When initialisation completes, error code 1 is cleared.
- R3: A read to a 32-bit partition requests the address with bits 1:0 cleared. It copies response bits 31:0 into read word 0 and leaves read word 1 unchanged.
- R4: A 64-bit partition (table bit PART_WIDE set) gets an address with bits 2:0 cleared and the wide flag set. A read fills word 0 from bits 31:0 and word 1 from bits 63:32. A program sends {wdata1, wdata0}; a 32-bit program sends {32'h0, wdata0}.
- R5: Status encodes 0 idle, 1 initialising, 2 error, 3 read in flight and 4 program in flight. A pending access takes precedence over error, and escalation forces 2.
- R6: Error code 2 is set, and no new access starts, in three cases: both command bits (cmd = 2'b11) are written; a command arrives while an access is in flight; or the address lies in no partition. An access already in flight still completes.
- R7: A read acknowledged with the correctable flag gives error code 3, and with the uncorrectable flag gives code 4 (uncorrectable wins). These flags are ignored on programs. Codes 2, 3 and 4 clear to 0 when the next command is accepted.
- R8: A read acknowledged with the fail flag gives code 5, and a program gives code 6. Both stay latched until reset, and every later command is refused without any access.
- R9: An escalation input sets code 7 on the next edge, drops any pending request and refuses all commands and init pulses until reset.
- R10: The completion interrupt pulses for one cycle after each acknowledged access. The error interrupt pulses for one cycle each time a nonzero error code is written.
- R11: A memory request stays asserted, with its address and data stable, until it is acknowledged or an escalation arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start initialisation (pulse) |
| esc_i | input | 1 | Escalation request |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_i | input | 2 | Command bits: bit 0 read, bit 1 program |
| addr_i | input | AW | Byte address |
| wdata0_i | input | DW | Program data, low word |
| wdata1_i | input | DW | Program data, high word |
| rdata0_o | output | DW | Read data, low word |
| rdata1_o | output | DW | Read data, high word |
| status_o | output | 3 | Status code |
| err_o | output | 3 | Error code |
| done_irq_o | output | 1 | Access completed pulse |
| err_irq_o | output | 1 | Error raised pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a program |
| mem_wide_o | output | 1 | 64-bit granule |
| mem_addr_o | output | AW | Aligned byte address |
| mem_wdata_o | output | 2*DW | Program data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 2*DW | Read data |
| mem_corr_i | input | 1 | Correctable error flag |
| mem_uncorr_i | input | 1 | Uncorrectable error flag |
| mem_fail_i | input | 1 | Access failure flag |

## Verification
The hardest situation to reach is a second command arriving while the memory acknowledge is held off. In that case the new error must be reported without disturbing the access in flight. The bench withholds the acknowledge on purpose, issues the second command in that window, and only then acknowledges. Escalation in the middle of an access is created the same way. The random phase varies the acknowledge latency and the correction flags across every partition, so that alignment and granule selection are exercised at many offsets.

// File: rtl/otp_cmd_pkg.sv
`timescale 1ns/1ps
package otp_cmd_pkg;

  typedef enum logic [2:0] {
    STAT_IDLE    = 3'd0,
    STAT_INIT    = 3'd1,
    STAT_ERROR   = 3'd2,
    STAT_RD_PEND = 3'd3,
    STAT_WR_PEND = 3'd4
  } stat_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_NO_INIT   = 3'd1,
    ERR_BAD_CMD   = 3'd2,
    ERR_RD_CORR   = 3'd3,
    ERR_RD_UNCORR = 3'd4,
    ERR_RD_FAIL   = 3'd5,
    ERR_WR_FAIL   = 3'd6,
    ERR_ESC       = 3'd7
  } err_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD   = 2'd1,
    SQ_WR   = 2'd2
  } seq_e;

endpackage

// File: rtl/otp_part_map.sv
`timescale 1ns/1ps
module otp_part_map #(
  parameter int AW       = 11,
  parameter int NUM_PART = 4,
  parameter logic [NUM_PART*AW-1:0] PART_BASE = {11'h640, 11'h600, 11'h300, 11'h000},
  parameter logic [NUM_PART*AW-1:0] PART_SIZE = {11'h040, 11'h040, 11'h300, 11'h300},
  parameter logic [NUM_PART-1:0]    PART_WIDE = 4'b1100
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          wide_o
);

  logic [NUM_PART-1:0] match;
  logic [AW:0]         addr_ext;

  assign addr_ext = {1'b0, addr_i};

  for (genvar g = 0; g < NUM_PART; g++) begin : g_part
    localparam logic [AW:0] LO = {1'b0, PART_BASE[g*AW +: AW]};
    localparam logic [AW:0] HI = LO + {1'b0, PART_SIZE[g*AW +: AW]};
    assign match[g] = (addr_ext >= LO) && (addr_ext < HI);
  end

  // lowest-numbered matching partition decides the granule
  always_comb begin
    hit_o  = |match;
    wide_o = 1'b0;
    for (int i = NUM_PART - 1; i >= 0; i--) begin
      if (match[i]) wide_o = PART_WIDE[i];
    end
  end

endmodule

// File: rtl/otp_init_ctr.sv
`timescale 1ns/1ps
module otp_init_ctr #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic last_o
);

  localparam int CW = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(INIT_CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign last_o = busy_o && (cnt_q == '0) && !abort_i;

endmodule

// File: rtl/otp_err_track.sv
`timescale 1ns/1ps
module otp_err_track
  import otp_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic esc_i,
  input  logic set_i,
  input  err_e code_i,
  input  logic clr_i,
  input  logic init_done_i,
  output err_e err_o,
  output logic irq_o,
  output logic fatal_o,
  output logic escalated_o
);

  err_e err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= ERR_NONE;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (err_q == ERR_ESC) begin
        err_q <= ERR_ESC;
      end else if (esc_i) begin
        err_q <= ERR_ESC;
        irq_o <= 1'b1;
      end else if (fatal_o) begin
        err_q <= err_q;
      end else if (set_i) begin
        err_q <= code_i;
        irq_o <= 1'b1;
      end else if (clr_i) begin
        err_q <= ERR_NONE;
      end else if (init_done_i && err_q == ERR_NO_INIT) begin
        err_q <= ERR_NONE;
      end
    end
  end

  assign err_o       = err_q;
  assign fatal_o     = (err_q == ERR_RD_FAIL) || (err_q == ERR_WR_FAIL);
  assign escalated_o = (err_q == ERR_ESC);

endmodule

// File: rtl/otp_cmd_seq.sv
`timescale 1ns/1ps
module otp_cmd_seq
  import otp_cmd_pkg::*;
#(
  parameter int AW          = 11,
  parameter int DW          = 32,
  parameter int NUM_PART    = 4,
  parameter logic [NUM_PART*AW-1:0] PART_BASE = {11'h640, 11'h600, 11'h300, 11'h000},
  parameter logic [NUM_PART*AW-1:0] PART_SIZE = {11'h040, 11'h040, 11'h300, 11'h300},
  parameter logic [NUM_PART-1:0]    PART_WIDE = 4'b1100,
  parameter int INIT_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_i,
  input  logic            esc_i,
  input  logic            cmd_we_i,
  input  logic [1:0]      cmd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata0_i,
  input  logic [DW-1:0]   wdata1_i,
  output logic [DW-1:0]   rdata0_o,
  output logic [DW-1:0]   rdata1_o,
  output logic [2:0]      status_o,
  output logic [2:0]      err_o,
  output logic            done_irq_o,
  output logic            err_irq_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_wide_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [2*DW-1:0] mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [2*DW-1:0] mem_rdata_i,
  input  logic            mem_corr_i,
  input  logic            mem_uncorr_i,
  input  logic            mem_fail_i
);

  localparam int NB_NARROW = $clog2(DW / 8);
  localparam int NB_WIDE   = NB_NARROW + 1;
  localparam logic [AW-1:0] MASK_NARROW = AW'((1 << NB_NARROW) - 1);
  localparam logic [AW-1:0] MASK_WIDE   = AW'((1 << NB_WIDE) - 1);

  seq_e sq_q;
  logic inited_q;
  logic init_busy, init_last, init_go;
  logic hit, wide;
  err_e err_cur, set_code, cmp_code, cmd_code;
  logic fatal, escalated, err_irq;
  logic cmd_seen, op_busy, blocked, accept, complete;
  logic cmp_set, cmd_set;

  otp_part_map #(
    .AW(AW), .NUM_PART(NUM_PART),
    .PART_BASE(PART_BASE), .PART_SIZE(PART_SIZE), .PART_WIDE(PART_WIDE)
  ) u_map (
    .addr_i (addr_i),
    .hit_o  (hit),
    .wide_o (wide)
  );

  otp_init_ctr #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk     (clk),
    .rst     (rst),
    .start_i (init_go),
    .abort_i (esc_i),
    .busy_o  (init_busy),
    .last_o  (init_last)
  );

  // command decode and completion classification
  always_comb begin
    cmd_seen = cmd_we_i && (cmd_i != 2'b00);
    op_busy  = (sq_q != SQ_IDLE);
    blocked  = escalated || fatal;
    complete = op_busy && mem_ack_i && !esc_i;

    cmp_set  = 1'b0;
    cmp_code = ERR_NONE;
    if (complete) begin
      if (mem_fail_i) begin
        cmp_set  = 1'b1;
        cmp_code = (sq_q == SQ_RD) ? ERR_RD_FAIL : ERR_WR_FAIL;
      end else if (sq_q == SQ_RD && mem_uncorr_i) begin
        cmp_set  = 1'b1;
        cmp_code = ERR_RD_UNCORR;
      end else if (sq_q == SQ_RD && mem_corr_i) begin
        cmp_set  = 1'b1;
        cmp_code = ERR_RD_CORR;
      end
    end

    cmd_set  = 1'b0;
    cmd_code = ERR_BAD_CMD;
    accept   = 1'b0;
    if (cmd_seen && !blocked) begin
      if (cmd_i == 2'b11 || op_busy) begin
        cmd_set = 1'b1;
      end else if (!inited_q || init_busy) begin
        cmd_set  = 1'b1;
        cmd_code = ERR_NO_INIT;
      end else if (!hit) begin
        cmd_set = 1'b1;
      end else begin
        accept = 1'b1;
      end
    end

    set_code = cmp_set ? cmp_code : cmd_code;
    init_go  = init_i && !escalated && !op_busy && !init_busy && !accept && !esc_i;
  end

  otp_err_track u_err (
    .clk         (clk),
    .rst         (rst),
    .esc_i       (esc_i),
    .set_i       (cmp_set || cmd_set),
    .code_i      (set_code),
    .clr_i       (accept),
    .init_done_i (init_last),
    .err_o       (err_cur),
    .irq_o       (err_irq),
    .fatal_o     (fatal),
    .escalated_o (escalated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inited_q <= 1'b0;
    end else if (init_go) begin
      inited_q <= 1'b0;
    end else if (init_last) begin
      inited_q <= 1'b1;
    end
  end

  // access sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q        <= SQ_IDLE;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_wide_o  <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rdata0_o    <= '0;
      rdata1_o    <= '0;
      done_irq_o  <= 1'b0;
    end else begin
      done_irq_o <= 1'b0;
      if (esc_i) begin
        sq_q      <= SQ_IDLE;
        mem_req_o <= 1'b0;
      end else if (accept) begin
        sq_q        <= cmd_i[0] ? SQ_RD : SQ_WR;
        mem_req_o   <= 1'b1;
        mem_we_o    <= cmd_i[1];
        mem_wide_o  <= wide;
        mem_addr_o  <= addr_i & ~(wide ? MASK_WIDE : MASK_NARROW);
        mem_wdata_o <= {(wide ? wdata1_i : {DW{1'b0}}), wdata0_i};
      end else if (complete) begin
        sq_q       <= SQ_IDLE;
        mem_req_o  <= 1'b0;
        done_irq_o <= 1'b1;
        if (sq_q == SQ_RD && !mem_fail_i) begin
          rdata0_o <= mem_rdata_i[DW-1:0];
          if (mem_wide_o) rdata1_o <= mem_rdata_i[2*DW-1:DW];
        end
      end
    end
  end

  always_comb begin
    if (escalated)               status_o = STAT_ERROR;
    else if (init_busy)          status_o = STAT_INIT;
    else if (sq_q == SQ_RD)      status_o = STAT_RD_PEND;
    else if (sq_q == SQ_WR)      status_o = STAT_WR_PEND;
    else if (err_cur != ERR_NONE) status_o = STAT_ERROR;
    else                         status_o = STAT_IDLE;
  end

  assign err_o     = err_cur;
  assign err_irq_o = err_irq;

endmodule

// File: rtl/otp_cmd_seq_chk.sv
`timescale 1ns/1ps
module otp_cmd_seq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          esc_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic          mem_we_o,
  input logic          mem_wide_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [2:0]    status_o,
  input logic [2:0]    err_o,
  input logic          done_irq_o,
  input logic          err_irq_o
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i && !esc_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && (!mem_wide_o || !mem_addr_o[2]))); // R4

  AST_PEND_STATUS: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && err_o != 3'd7) |-> (status_o == (mem_we_o ? 3'd4 : 3'd3))); // R5

  AST_INIT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (status_o == 3'd1) |-> !mem_req_o); // R2

  AST_FATAL_LATCH: assert property (@(posedge clk) disable iff (rst)
    ((err_o == 3'd5 || err_o == 3'd6) && !esc_i) |=> (err_o == $past(err_o))); // R8

  AST_ESC_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    (err_o == 3'd7) |=> (err_o == 3'd7 && !mem_req_o && status_o == 3'd2)); // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    done_irq_o |-> $past(mem_req_o && mem_ack_i)); // R10

  AST_ERR_IRQ_CODE: assert property (@(posedge clk) disable iff (rst)
    err_irq_o |-> (err_o != 3'd0)); // R10

endmodule

bind otp_cmd_seq otp_cmd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_otp_cmd_seq.sv
`timescale 1ns/1ps
module sim_otp_cmd_seq;

  localparam int AW = 11;
  localparam int DW = 32;
  localparam int INIT_CYCLES = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_i = 1'b0, esc_i = 1'b0, cmd_we_i = 1'b0;
  logic [1:0] cmd_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata0_i = '0, wdata1_i = '0;
  logic [DW-1:0] rdata0_o, rdata1_o;
  logic [2:0] status_o, err_o;
  logic done_irq_o, err_irq_o;
  logic mem_req_o, mem_we_o, mem_wide_o;
  logic [AW-1:0] mem_addr_o;
  logic [2*DW-1:0] mem_wdata_o;
  logic mem_ack_i = 1'b0;
  logic [2*DW-1:0] mem_rdata_i = '0;
  logic mem_corr_i = 1'b0, mem_uncorr_i = 1'b0, mem_fail_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] exp_rd0 = '0, exp_rd1 = '0;

  always #2.5 clk = ~clk;

  otp_cmd_seq #(.INIT_CYCLES(INIT_CYCLES)) u0 (.*);

  // partition table as the requirements define it
  function automatic logic f_hit(input logic [AW-1:0] a);
    return a < 11'h680;
  endfunction
  function automatic logic f_wide(input logic [AW-1:0] a);
    return (a >= 11'h600) && (a < 11'h680);
  endfunction
  function automatic logic [AW-1:0] f_align(input logic [AW-1:0] a);
    return f_wide(a) ? {a[AW-1:3], 3'b000} : {a[AW-1:2], 2'b00};
  endfunction
  function automatic logic [2:0] f_err(input logic wr, input logic c, input logic u, input logic f);
    if (f) return wr ? 3'd6 : 3'd5;
    if (!wr && u) return 3'd4;
    if (!wr && c) return 3'd3;
    return 3'd0;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [1:0] bits);
    cmd_we_i = 1'b1;
    cmd_i = bits;
    @(negedge clk);
    cmd_we_i = 1'b0;
    cmd_i = 2'b00;
  endtask

  task automatic ack(input logic [63:0] d, input logic c, input logic u, input logic f);
    mem_ack_i = 1'b1; mem_rdata_i = d;
    mem_corr_i = c; mem_uncorr_i = u; mem_fail_i = f;
    @(negedge clk);
    mem_ack_i = 1'b0; mem_corr_i = 1'b0; mem_uncorr_i = 1'b0; mem_fail_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_rd0 = '0;
    exp_rd1 = '0;
  endtask

  task automatic do_init();
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk("R2 status init", status_o, 3'd1);
    repeat (INIT_CYCLES - 1) @(negedge clk);
    chk("R2 status still init", status_o, 3'd1);
    @(negedge clk);
    chk("R5 status idle after init", status_o, 3'd0);
  endtask

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] w0,
                       input logic [DW-1:0] w1, input logic [63:0] d, input logic c,
                       input logic u, input logic f, input int lat);
    logic wd;
    logic [2:0] ee;
    wd = f_wide(a);
    addr_i = a; wdata0_i = w0; wdata1_i = w1;
    issue(wr ? 2'b10 : 2'b01);
    chk("R11 req raised", mem_req_o, 1'b1);
    chk("R3 aligned addr", mem_addr_o, f_align(a));
    chk("R4 granule", mem_wide_o, wd);
    chk("R5 pending status", status_o, wr ? 3'd4 : 3'd3);
    chk("R7 cleared on accept", err_o, 3'd0);
    if (wr) chk("R4 program data", mem_wdata_o, {(wd ? w1 : 32'h0), w0});
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R11 req held", mem_req_o, 1'b1);
    end
    ack(d, c, u, f);
    ee = f_err(wr, c, u, f);
    chk("R10 done pulse", done_irq_o, 1'b1);
    chk("R11 req dropped", mem_req_o, 1'b0);
    chk("R7 R8 code", err_o, ee);
    chk("R10 err irq", err_irq_o, ee != 3'd0);
    chk("R5 status after", status_o, (ee != 3'd0) ? 3'd2 : 3'd0);
    if (!wr && !f) begin
      exp_rd0 = d[31:0];
      if (wd) exp_rd1 = d[63:32];
    end
    chk("R3 read word0", rdata0_o, exp_rd0);
    chk("R4 read word1", rdata1_o, exp_rd1);
    @(negedge clk);
    chk("R10 done one cycle", done_irq_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    do_reset();
    chk("R1 status", status_o, 3'd0);
    chk("R1 err", err_o, 3'd0);
    chk("R1 req", mem_req_o, 1'b0);
    chk("R1 done", done_irq_o, 1'b0);
    chk("R1 err irq", err_irq_o, 1'b0);

    // command before init
    addr_i = 11'h010;
    issue(2'b01);
    chk("R2 missing init code", err_o, 3'd1);
    chk("R2 no access", mem_req_o, 1'b0);
    chk("R10 irq on missing init", err_irq_o, 1'b1);
    chk("R5 error status", status_o, 3'd2);
    @(negedge clk);
    chk("R10 irq single pulse", err_irq_o, 1'b0);
    do_init();
    chk("R2 cleared by init", err_o, 3'd0);

    // directed accesses
    do_op(1'b0, 11'h013, 32'h0, 32'h0, 64'hAAAA_BBBB_1234_5678, 0, 0, 0, 2);
    do_op(1'b0, 11'h605, 32'h0, 32'h0, 64'hCAFE_F00D_0BAD_BEEF, 0, 0, 0, 0);
    do_op(1'b1, 11'h306, 32'h1111_2222, 32'h3333_4444, 64'h0, 0, 0, 0, 1);
    do_op(1'b1, 11'h64F, 32'h5555_6666, 32'h7777_8888, 64'h0, 0, 0, 0, 3);

    // both bits
    issue(2'b11);
    chk("R6 both bits code", err_o, 3'd2);
    chk("R6 both bits no access", mem_req_o, 1'b0);
    // outside every partition
    addr_i = 11'h700;
    issue(2'b01);
    chk("R6 unmapped code", err_o, 3'd2);
    chk("R6 unmapped no access", mem_req_o, 1'b0);

    // command while pending
    addr_i = 11'h020;
    issue(2'b01);
    chk("R5 read pending", status_o, 3'd3);
    issue(2'b10);
    chk("R6 busy code", err_o, 3'd2);
    chk("R6 busy keeps access", mem_req_o, 1'b1);
    chk("R6 busy keeps direction", mem_we_o, 1'b0);
    chk("R5 pending wins over error", status_o, 3'd3);
    ack(64'h0000_0000_9999_0000, 0, 0, 0);
    exp_rd0 = 32'h9999_0000;
    chk("R6 pending read completes", done_irq_o, 1'b1);
    chk("R6 busy code kept", err_o, 3'd2);
    chk("R3 pending read data", rdata0_o, exp_rd0);

    // correction flags
    do_op(1'b0, 11'h100, 32'h0, 32'h0, 64'h1, 1, 0, 0, 1);
    do_op(1'b0, 11'h610, 32'h0, 32'h0, 64'h2_0000_0003, 1, 1, 0, 0);
    do_op(1'b1, 11'h104, 32'hABCD, 32'h0, 64'h0, 1, 1, 0, 0);

    // random phase
    for (int n = 0; n < 40; n++) begin
      int p, sel;
      logic [AW-1:0] a;
      logic wr;
      p = $urandom_range(0, 3);
      case (p)
        0: a = AW'($urandom_range(0, 11'h2FF));
        1: a = AW'(11'h300 + $urandom_range(0, 11'h2FF));
        2: a = AW'(11'h600 + $urandom_range(0, 11'h3F));
        default: a = AW'(11'h640 + $urandom_range(0, 11'h3F));
      endcase
      wr = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 3);
      do_op(wr, a, $urandom, $urandom, {$urandom, $urandom},
            sel == 1, sel == 2, 1'b0, $urandom_range(0, 4));
    end
    chk("R3 random map sanity", f_hit(11'h67F), 1'b1);

    // read failure latches
    do_op(1'b0, 11'h040, 32'h0, 32'h0, 64'h0, 0, 0, 1, 1);
    addr_i = 11'h044;
    issue(2'b01);
    chk("R8 refused after fail", mem_req_o, 1'b0);
    chk("R8 code latched", err_o, 3'd5);
    chk("R8 no new irq", err_irq_o, 1'b0);
    do_reset();
    chk("R1 reset clears fail", err_o, 3'd0);
    do_init();
    do_op(1'b1, 11'h620, 32'h1, 32'h2, 64'h0, 0, 0, 1, 0);
    issue(2'b10);
    chk("R8 program fail latched", err_o, 3'd6);
    chk("R8 program fail refuses", mem_req_o, 1'b0);

    // escalation during an access
    do_reset();
    do_init();
    addr_i = 11'h200;
    issue(2'b01);
    esc_i = 1'b1;
    @(negedge clk);
    esc_i = 1'b0;
    chk("R9 escalated code", err_o, 3'd7);
    chk("R9 request dropped", mem_req_o, 1'b0);
    chk("R10 irq on escalation", err_irq_o, 1'b1);
    chk("R9 error status", status_o, 3'd2);
    issue(2'b01);
    chk("R9 command refused", mem_req_o, 1'b0);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk("R9 init refused", status_o, 3'd2);
    chk("R9 still escalated", err_o, 3'd7);
    chk("R10 no done after abort", done_irq_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule